// File: doc/BRIEF.md
# Two-Class Fixed-Priority Memory Port Arbiter

This block decides which of five requesters may use a single memory module next. Two of the requesters are I/O controllers and three are processors. Each requester raises a request line and holds it until it sees a one-cycle acknowledge. The acknowledge also starts a memory cycle of fixed length, and the module is busy for all of that cycle. The arbiter makes a new decision only when the module is free. At every decision it sorts the pending requests into two classes. The I/O class always beats the processor class. Inside each class the lowest port index wins.

A requester that loses keeps its request asserted and is served at a later decision. A requester that withdraws its request before it is acknowledged gets nothing. The block drives the winner's index, an acknowledge vector and a busy flag. It contains no memory array and no data path.

Top module: `mem_port_arbiter`

## Requirements
- R1: During and right after reset, `ack_o` is all zeros, `busy_o` is low and `owner_o` is 0.
- R2: While no request is present, `ack_o` stays zero and `busy_o` stays low.
- R3: Port bits 0 and 1 form the I/O class and bits 2 to 4 form the processor class. When any I/O bit is pending at a decision, the acknowledge goes to an I/O port.
- R4: Inside a class, the lowest pending bit index wins. Bit 0 beats bit 1, and bit 2 beats bit 3, which beats bit 4.
- R5: A decision taken at a clock edge drives a one-hot `ack_o` for exactly one cycle after that edge. From that cycle on, `owner_o` shows the winner's index and keeps it until the next acknowledge. A request raised while the module is idle is acknowledged one cycle later.
- R6: `busy_o` goes high in the acknowledge cycle and stays high for exactly `CYCLE_CLKS` cycles. If a request is pending when the cycle ends, the next acknowledge comes exactly `CYCLE_CLKS` cycles after the previous one.
- R7: A running memory cycle is never cut short. A higher-priority request that arrives during a cycle waits for the cycle to end.
- R8: A losing requester stays pending and is served later. Each held request gets exactly one acknowledge.
- R9: A request that is withdrawn before it is acknowledged gets no acknowledge.
- R10: While I/O requests are pending at every decision, a pending processor request gets no acknowledge. This starvation is the intended behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 5 | Request per port: bits 1:0 are the I/O controllers, bits 4:2 are the processors |
| ack_o | output | 5 | One-cycle acknowledge per port; it marks the start of that port's memory cycle |
| owner_o | output | 3 | Index of the port that was acknowledged last |
| busy_o | output | 1 | High while a memory cycle is in progress |

## Verification
The timing rules are as follows:
- From an idle module, an acknowledge is due in the first cycle after the request is raised.
- Each further acknowledge in a queue is due exactly `CYCLE_CLKS` cycles after the one before it.
- `busy_o` must fall exactly `CYCLE_CLKS` cycles after the last acknowledge.

The bench drives requests on falling edges and records the cycle count at each stimulus. A monitor samples on the next falling edge. It compares each acknowledge against a queue of expected winners, each entry tagged with its due distance. Any acknowledge that is early, late, unexpected or sent to a withdrawn port is therefore counted as a miscompare.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    CLS_IO  = 1'b0,
    CLS_CPU = 1'b1
  } arb_class_e;
endpackage

// File: rtl/arb_fixed_prio.sv
module arb_fixed_prio #(
  parameter int unsigned WIDTH = 2
) (
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] gnt_o,
  output logic             any_o
);
  logic [WIDTH:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    assign gnt_o[i]   = req_i[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req_i[i];
  end

  assign any_o = taken[WIDTH];

  always_comb begin
    // R4
    gnt_subset_chk: assert ((gnt_o & ~req_i) == '0 && $onehot0(gnt_o));
  end
endmodule

// File: rtl/arb_cycle_timer.sv
module arb_cycle_timer #(
  parameter int unsigned CYCLE_CLKS = 150,
  localparam int unsigned CNT_W = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic last_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLE_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == '0);

  // R6
  busy_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !busy_o);

  // R7
  start_when_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (!busy_o || last_o));
endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned IO_PORTS   = 2,
  parameter int unsigned CPU_PORTS  = 3,
  parameter int unsigned CYCLE_CLKS = 150,
  localparam int unsigned NUM_REQ = IO_PORTS + CPU_PORTS,
  localparam int unsigned IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] ack_o,
  output logic [IDX_W-1:0]   owner_o,
  output logic               busy_o
);
  logic [IO_PORTS-1:0]  io_gnt;
  logic [CPU_PORTS-1:0] cpu_gnt;
  logic                 io_any;
  logic                 cpu_any;
  logic [NUM_REQ-1:0]   win;
  logic [IDX_W-1:0]     win_idx;
  arb_class_e           win_cls;
  logic                 busy;
  logic                 last;
  logic                 start;
  logic [NUM_REQ-1:0]   ack_q;
  logic [IDX_W-1:0]     owner_q;

  arb_fixed_prio #(.WIDTH(IO_PORTS)) u_io_pick (
    .req_i (req_i[IO_PORTS-1:0]),
    .gnt_o (io_gnt),
    .any_o (io_any)
  );

  arb_fixed_prio #(.WIDTH(CPU_PORTS)) u_cpu_pick (
    .req_i (req_i[NUM_REQ-1:IO_PORTS]),
    .gnt_o (cpu_gnt),
    .any_o (cpu_any)
  );

  assign win_cls = io_any ? CLS_IO : CLS_CPU;
  assign win     = (win_cls == CLS_IO) ? {{CPU_PORTS{1'b0}}, io_gnt}
                                       : {cpu_gnt, {IO_PORTS{1'b0}}};

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (win[i]) win_idx = IDX_W'(i);
    end
  end

  // decide only when the module is free or its cycle ends this edge
  assign start = (io_any || cpu_any) && (!busy || last);

  arb_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= '0;
      owner_q <= '0;
    end else begin
      ack_q <= start ? win : '0;
      if (start) owner_q <= win_idx;
    end
  end

  assign ack_o   = ack_q;
  assign owner_o = owner_q;
  assign busy_o  = busy;

  // R5
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o) && (!(|ack_o) || busy_o));

  // R5
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|ack_o) && (CYCLE_CLKS > 1)) |=> (ack_o == '0));

  // R9
  ack_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> ((ack_o & ~$past(req_i)) == '0));

  // R3
  io_class_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o[NUM_REQ-1:IO_PORTS]) |-> ($past(req_i[IO_PORTS-1:0]) == '0));

  // R7
  no_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last) |=> (ack_o == '0));
endmodule

// File: tb/tb_mem_port_arbiter.sv
`timescale 1ns/1ps
module tb_mem_port_arbiter;
  localparam int NIO  = 2;
  localparam int NCPU = 3;
  localparam int NREQ = NIO + NCPU;
  localparam int IW   = 3;
  localparam int CYC  = 150;

  logic            clk_i  = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NREQ-1:0] req_i  = '0;
  logic [NREQ-1:0] ack_o;
  logic [IW-1:0]   owner_o;
  logic            busy_o;

  always #2.5 clk_i = ~clk_i;

  mem_port_arbiter #(.IO_PORTS(NIO), .CPU_PORTS(NCPU), .CYCLE_CLKS(CYC)) dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .ack_o   (ack_o),
    .owner_o (owner_o),
    .busy_o  (busy_o)
  );

  typedef struct {
    int    idx;
    int    gap;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   vectors     = 0;
  int   miscompares = 0;
  int   cyc         = 0;
  int   mark        = 0;
  int   last_ack    = 0;
  bit   prev_busy   = 1'b0;
  bit   refill      = 1'b0;
  bit   done        = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push(int idx, int gap, string tag);
    exp_t e;
    e.idx = idx; e.gap = gap; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic raise(logic [NREQ-1:0] m);
    if (!busy_o && exp_q.size() == 0) mark = cyc;
    req_i = req_i | m;
  endtask

  // monitor: one falling edge per call
  task automatic step();
    @(negedge clk_i);
    cyc++;
    if (|ack_o) begin
      int   a;
      exp_t e;
      a = 0;
      for (int i = 0; i < NREQ; i++) if (ack_o[i]) a = i;
      chk(req_i[a] == 1'b1, "R9", "ack to port without request", a, -1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected ack on port", a, -1);
      end else begin
        e = exp_q.pop_front();
        chk(ack_o == NREQ'(1 << e.idx), e.tag, "ack vector", int'(ack_o), 1 << e.idx);
        chk(int'(owner_o) == e.idx, "R5", "owner index", int'(owner_o), e.idx);
        chk(busy_o == 1'b1, "R6", "busy in ack cycle", int'(busy_o), 1);
        if (e.gap > 0) chk(cyc - mark == e.gap, e.tag, "ack latency", cyc - mark, e.gap);
      end
      mark     = cyc;
      last_ack = cyc;
      req_i[a] = 1'b0;
      if (refill && a < NIO) req_i[a] = 1'b1;
    end
    if (prev_busy && !busy_o)
      chk(cyc - last_ack == CYC, "R6", "busy length", cyc - last_ack, CYC);
    prev_busy = busy_o;
  endtask

  task automatic drain();
    for (int k = 0; k < 6000 && (exp_q.size() != 0 || busy_o); k++) step();
    chk(exp_q.size() == 0, "R8", "outstanding acks", exp_q.size(), 0);
    for (int k = 0; k < 5; k++) step();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    chk(ack_o == '0, "R1", "ack in reset", int'(ack_o), 0);
    chk(busy_o == 1'b0, "R1", "busy in reset", int'(busy_o), 0);
    chk(owner_o == '0, "R1", "owner in reset", int'(owner_o), 0);
    rst_ni = 1'b1;
    step();
    chk(ack_o == '0 && !busy_o, "R1", "state after reset", int'(ack_o), 0);

    // R2 idle
    for (int k = 0; k < 20; k++) begin
      step();
      chk(ack_o == '0 && !busy_o, "R2", "idle activity", int'({busy_o, ack_o}), 0);
    end

    // R3/R4/R8: all five at once
    raise(5'b11111);
    push(0, 1, "R3"); push(1, CYC, "R4"); push(2, CYC, "R3");
    push(3, CYC, "R4"); push(4, CYC, "R8");
    drain();
    chk(int'(owner_o) == 4, "R5", "owner held after idle", int'(owner_o), 4);

    // R4 processor order
    raise(5'b11000);
    push(3, 1, "R4"); push(4, CYC, "R4");
    drain();

    // R7: higher-priority arrivals wait for the running cycle
    raise(5'b00100);
    push(2, 1, "R5");
    step();
    for (int k = 0; k < 10; k++) step();
    raise(5'b01010);
    push(1, CYC, "R7"); push(3, CYC, "R3");
    drain();

    // R9: withdrawn request
    raise(5'b10001);
    push(0, 1, "R3");
    step();
    for (int k = 0; k < 20; k++) step();
    req_i[4] = 1'b0;
    drain();
    for (int k = 0; k < 30; k++) step();
    chk(!busy_o && ack_o == '0, "R9", "withdrawn port idle", int'({busy_o, ack_o}), 0);

    // R10: continuous I/O load holds the processor off
    refill = 1'b1;
    raise(5'b00101);
    push(0, 1, "R10");
    for (int k = 0; k < 5; k++) push(0, CYC, "R10");
    for (int k = 0; k < 6000 && exp_q.size() != 0; k++) step();
    chk(req_i[2] == 1'b1, "R10", "processor still pending", int'(req_i[2]), 1);
    $display("note: processor port held off for %0d grants under I/O load (expected)", 6);
    refill = 1'b0;
    push(0, CYC, "R10"); push(2, CYC, "R8");
    drain();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule